// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block forms the data memory address for an 8-bit microcontroller whose data space is cut into sixteen 256-byte banks. It takes the low ten bits of a byte-oriented instruction: an 8-bit file offset, a window-select bit and a destination bit. It also holds a 4-bit bank pointer that has its own write port. From these it produces a 12-bit effective address, and it reports whether the instruction result goes to the working register or back to the addressed file register.

When the window-select bit is clear, the bank pointer plays no part. The offset then falls in a 256-byte window that is split in two. Offsets below 0x60 reach the bottom of bank 0, and offsets from 0x60 upward reach the top of bank 15, where the special registers sit. When the window-select bit is set, the bank pointer supplies the upper four address bits.

A small byte-wide data RAM sits behind the address. It has one combinational read port and one write path. Software or an external ALU reads the addressed byte, computes a result, and presents it with an operation strobe. The byte is written back only when the destination bit selects the file register.

Top module: `bnk_addr_top`

## Requirements
- R1: With the window-select bit (instruction bit 8) at 1, the effective address equals the stored bank pointer in bits 11:8 and the file offset in bits 7:0.
- R2: With the window-select bit at 0 and an offset below 0x60, the effective address is 0x000 plus the offset, whatever the bank pointer holds.
- R3: With the window-select bit at 0 and an offset of 0x60 or above, the effective address is 0xF00 plus the offset, whatever the bank pointer holds.
- R4: The instruction field is 10 bits. Bits 7:0 are the file offset, bit 8 selects the window and bit 9 is the destination; address bits 7:0 always equal field bits 7:0.
- R5: `dest_file` equals instruction bit 9. `wreg_we` is high exactly when `op_stb` is high and bit 9 is 0.
- R6: A bank pointer write stores only the low 4 bits of `bank_wdata`, takes effect at the next rising clock edge, and an operation in the same cycle still uses the old pointer.
- R7: After reset the bank pointer is 0.
- R8: With `op_stb` high and bit 9 at 1, `res_data` is written at the effective address at the clock edge, and `file_rdata` shows it afterwards.
- R9: With `op_stb` high and bit 9 at 0, the data RAM is left unchanged.
- R10: `file_rdata` shows, without a clock edge, the byte stored at the current effective address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_we | input | 1 | Bank pointer write enable |
| bank_wdata | input | 8 | Bank pointer write data, low 4 bits kept |
| insn_fld | input | 10 | Instruction bits 9:0 (dest, window select, offset) |
| op_stb | input | 1 | Operation strobe for the read/modify/write |
| res_data | input | 8 | Result byte to write back |
| eff_addr | output | 12 | Effective data memory address |
| dest_file | output | 1 | 1: result to file register, 0: to working register |
| wreg_we | output | 1 | Working register write pulse |
| file_rdata | output | 8 | Byte at the effective address |

## Verification
The write-back and no-write properties assume that the instruction field and the bank pointer stay put across the edge that ends an operation. They only judge `file_rdata` when the field is unchanged and no bank write was pending, because otherwise the address has moved. The random stimulus holds each field for one step and predicts the moved address in the model when it changes. The stimulus reads only bytes that the bench has written, so never-written RAM contents play no part in any check.

// File: rtl/bnk_pkg.sv
package bnk_pkg;
    parameter int OFS_W   = 8;
    parameter int BANK_W  = 4;
    parameter int DATA_W  = 8;
    parameter int ADDR_W  = OFS_W + BANK_W;
    parameter int INSN_W  = OFS_W + 2;
    parameter int SEL_BIT = OFS_W;
    parameter int DST_BIT = OFS_W + 1;
    parameter logic [OFS_W-1:0] WIN_SPLIT = 8'h60;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } bank_state_t;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic             sel;
        logic             dst;
    } insn_dec_t;
endpackage

// File: rtl/bnk_sel_reg.sv
module bnk_sel_reg
    import bnk_pkg::*;
#(
    parameter int WD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WD_W-1:0]   wdata,
    output logic [BANK_W-1:0] bank
);
    bank_state_t st_d, st_q;

    logic unused_hi;
    generate
        if (WD_W > BANK_W) begin : g_wide
            assign unused_hi = ^wdata[WD_W-1:BANK_W];
        end else begin : g_narrow
            assign unused_hi = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.bank = wdata[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank = st_q.bank;
endmodule

// File: rtl/bnk_addr_map.sv
module bnk_addr_map
    import bnk_pkg::*;
#(
    parameter logic [OFS_W-1:0] SPLIT = WIN_SPLIT
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic              sel,
    input  logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [BANK_W-1:0] LOW_BANK = '0;
    localparam logic [BANK_W-1:0] TOP_BANK = '1;

    logic [BANK_W-1:0] win_bank;

    generate
        if (SPLIT == '0) begin : g_all_top
            assign win_bank = TOP_BANK;
        end else begin : g_split
            always_comb begin
                if (ofs < SPLIT) begin
                    win_bank = LOW_BANK;
                end else begin
                    win_bank = TOP_BANK;
                end
            end
        end
    endgenerate

    always_comb begin
        if (sel) begin
            addr = {bank, ofs};
        end else begin
            addr = {win_bank, ofs};
        end
    end
endmodule

// File: rtl/bnk_data_ram.sv
module bnk_data_ram
    import bnk_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/bnk_addr_top.sv
module bnk_addr_top
    import bnk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [7:0]        bank_wdata,
    input  logic [INSN_W-1:0] insn_fld,
    input  logic              op_stb,
    input  logic [DATA_W-1:0] res_data,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              dest_file,
    output logic              wreg_we,
    output logic [DATA_W-1:0] file_rdata
);
    insn_dec_t         dec;
    logic [BANK_W-1:0] bank_q;
    logic              ram_we;

    always_comb begin
        dec.ofs = insn_fld[OFS_W-1:0];
        dec.sel = insn_fld[SEL_BIT];
        dec.dst = insn_fld[DST_BIT];
    end

    bnk_sel_reg #(.WD_W(8)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .wdata (bank_wdata),
        .bank  (bank_q)
    );

    bnk_addr_map #(.SPLIT(WIN_SPLIT)) u_map (
        .ofs  (dec.ofs),
        .sel  (dec.sel),
        .bank (bank_q),
        .addr (eff_addr)
    );

    assign ram_we    = op_stb & dec.dst & rst_n;
    assign dest_file = dec.dst;
    assign wreg_we   = op_stb & ~dec.dst;

    bnk_data_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (eff_addr),
        .wdata (res_data),
        .rdata (file_rdata)
    );
endmodule

// File: rtl/bnk_addr_chk.sv
module bnk_addr_chk
    import bnk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bank_we,
    input logic [7:0]        bank_wdata,
    input logic [INSN_W-1:0] insn_fld,
    input logic              op_stb,
    input logic [DATA_W-1:0] res_data,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              dest_file,
    input logic              wreg_we,
    input logic [DATA_W-1:0] file_rdata
);
    p_low_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_fld[SEL_BIT] && insn_fld[OFS_W-1:0] < WIN_SPLIT)
            |-> eff_addr[ADDR_W-1:OFS_W] == '0);

    p_high_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_fld[SEL_BIT] && insn_fld[OFS_W-1:0] >= WIN_SPLIT)
            |-> eff_addr[ADDR_W-1:OFS_W] == '1);

    p_ofs_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eff_addr[OFS_W-1:0] == insn_fld[OFS_W-1:0]);

    p_wreg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wreg_we |-> (op_stb && !dest_file));

    p_bank_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (!insn_fld[SEL_BIT]
                     || eff_addr[ADDR_W-1:OFS_W] == $past(bank_wdata[BANK_W-1:0])));

    p_bank_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_we && insn_fld[SEL_BIT]) |=> (!insn_fld[SEL_BIT]
                     || eff_addr[ADDR_W-1:OFS_W] == $past(eff_addr[ADDR_W-1:OFS_W])));

    p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && insn_fld[DST_BIT] && !bank_we)
            |=> (insn_fld != $past(insn_fld) || file_rdata == $past(res_data)));

    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && !insn_fld[DST_BIT] && !bank_we)
            |=> (insn_fld != $past(insn_fld) || file_rdata == $past(file_rdata)));
endmodule

bind bnk_addr_top bnk_addr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_we    (bank_we),
    .bank_wdata (bank_wdata),
    .insn_fld   (insn_fld),
    .op_stb     (op_stb),
    .res_data   (res_data),
    .eff_addr   (eff_addr),
    .dest_file  (dest_file),
    .wreg_we    (wreg_we),
    .file_rdata (file_rdata)
);

// File: tb/bnk_addr_top_bench.sv
module bnk_addr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_we = 1'b0;
    logic [7:0]  bank_wdata = '0;
    logic [9:0]  insn_fld = '0;
    logic        op_stb = 1'b0;
    logic [7:0]  res_data = '0;
    logic [11:0] eff_addr;
    logic        dest_file;
    logic        wreg_we;
    logic [7:0]  file_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [3:0] m_bank = '0;
    logic [7:0] m_mem [4096];
    bit         m_vld [4096];

    always #2 clk = ~clk;

    bnk_addr_top u_bnk_addr_top (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
        .insn_fld(insn_fld), .op_stb(op_stb), .res_data(res_data),
        .eff_addr(eff_addr), .dest_file(dest_file), .wreg_we(wreg_we),
        .file_rdata(file_rdata)
    );

    function automatic logic [11:0] exp_addr(input logic [9:0] ins, input logic [3:0] bk);
        if (ins[8]) return {bk, ins[7:0]};
        if (ins[7:0] < 8'h60) return {4'h0, ins[7:0]};
        return {4'hF, ins[7:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_comb(input string tag);
        logic [11:0] ea;
        ea = exp_addr(insn_fld, m_bank);
        chk(eff_addr == ea, tag, eff_addr, ea);
        chk(dest_file == insn_fld[9], "R5 dest_file", dest_file, insn_fld[9]);
        chk(wreg_we == (op_stb & ~insn_fld[9]), "R5 wreg_we", wreg_we, op_stb & ~insn_fld[9]);
        if (m_vld[ea]) chk(file_rdata == m_mem[ea], "R10 read", file_rdata, m_mem[ea]);
    endtask

    task automatic step(input logic [9:0] ins, input bit bwe, input logic [7:0] bwd,
                        input bit stb, input logic [7:0] rd, input string tag);
        logic [11:0] ea;
        @(negedge clk);
        insn_fld = ins; bank_we = bwe; bank_wdata = bwd; op_stb = stb; res_data = rd;
        #1;
        check_comb(tag);
        ea = exp_addr(ins, m_bank);
        @(posedge clk);
        if (stb && ins[9]) begin m_mem[ea] = rd; m_vld[ea] = 1; end
        if (bwe) m_bank = bwd[3:0];
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4096; i++) m_vld[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: pointer clear after reset
        step(10'h133, 0, 8'h00, 0, 8'h00, "R7 reset bank");
        chk(eff_addr == 12'h033, "R7 reset addr", eff_addr, 12'h033);
        // R6: write 0xA7, only 7 kept, old value seen in the same cycle
        @(negedge clk);
        insn_fld = 10'h144; bank_we = 1; bank_wdata = 8'hA7; op_stb = 0; #1;
        chk(eff_addr == 12'h044, "R6 same-cycle old bank", eff_addr, 12'h044);
        @(posedge clk); m_bank = 4'h7;
        @(negedge clk); bank_we = 0; #1;
        chk(eff_addr == 12'h744, "R6 low nibble kept", eff_addr, 12'h744);
        // R2/R3 window boundaries with a nonzero bank
        step(10'h05F, 0, 0, 0, 0, "R2 last low");
        chk(eff_addr == 12'h05F, "R2 0x5F", eff_addr, 12'h05F);
        step(10'h060, 0, 0, 0, 0, "R3 first high");
        chk(eff_addr == 12'hF60, "R3 0x60", eff_addr, 12'hF60);
        step(10'h0FF, 0, 0, 0, 0, "R3 top");
        step(10'h000, 0, 0, 0, 0, "R2 bottom");
        // R8 write back, R9 no write
        step(10'h320, 0, 0, 1, 8'h5A, "R8 write");
        step(10'h320, 0, 0, 0, 0, "R8 readback");
        chk(file_rdata == 8'h5A, "R8 data", file_rdata, 8'h5A);
        step(10'h120, 0, 0, 1, 8'hC3, "R9 wreg op");
        step(10'h320, 0, 0, 0, 0, "R9 unchanged");
        chk(file_rdata == 8'h5A, "R9 data", file_rdata, 8'h5A);
        // R6: op in the same cycle as a bank write uses old bank
        step(10'h311, 1, 8'h03, 1, 8'h99, "R6 op with bank write");
        step(10'h111, 0, 0, 0, 0, "R6 new bank");
        chk(eff_addr == 12'h311, "R6 bank 3", eff_addr, 12'h311);
        step(10'h311, 1, 8'h07, 0, 0, "R6 back to 7");
        step(10'h311, 0, 0, 0, 0, "R6 old bank location");
        chk(file_rdata == 8'h99, "R6 write used old bank", file_rdata, 8'h99);
        // R1/R4 random mix
        for (int i = 0; i < 600; i++) begin
            logic [9:0] ins;
            ins = 10'($urandom);
            if (i % 5 == 0) ins[7:0] = (($urandom % 2) != 0) ? 8'h5F : 8'h60;
            step(ins, ($urandom % 6) == 0, 8'($urandom), ($urandom % 2) == 1,
                 8'($urandom), "R1 R4 random addr");
        end
        summary();
    end
endmodule